// File: doc/BRIEF.md
# Blit Rectangle Setup and Clip Unit

This unit sits in front of a 2D copy engine. Software programs a blit one 32-bit word at a time into a small indexed register bank. The last word of a blit is the upper half of the source Y coordinate. Its arrival launches a computation, provided the selected operation is a plain source copy. The computation turns the programmed start points, extents and fixed-point steps into one integer source rectangle and one integer destination rectangle.

Source positions and steps are 32.32 fixed point. The source end point comes from one of two origin modes:
- **Stepped mode:** the source end is projected through the per-pixel step.
- **Direct mode:** the destination extent is added to the integer source start.

Both rectangles are then trimmed in two passes. The first pass keeps the source inside the source surface and shrinks the destination in proportion. The second pass keeps the destination inside the destination surface and shrinks the source in proportion. X and Y are handled independently.

The proportional shrink needs an integer divide. Each axis has its own sequential divider. A `busy` output covers the whole computation, and a one-cycle `done` pulse marks the moment the rectangles and filter mode are presented, for the downstream engine to consume.

Top module: `blit_clip_unit`

## Requirements
- R1: After reset, `busy`, `done`, `op_err` and `idx_err` are low, and every rectangle output and `filter` are zero. All register words are zero, so the operation word initially selects copy (code 0).
- R2: A write with `wr_idx` below 18 stores `wr_data` into that word. A write with `wr_idx` of 18 or more changes no word and raises `idx_err` for the one cycle after the write. The register word map is:
  - 0: operation
  - 1: control (bit 0 = stepped origin, bits 2:1 = filter)
  - 2 and 3: source surface width and height
  - 4 and 5: destination surface width and height
  - 6 and 7: destination X and Y
  - 8 and 9: destination width and height
  - 10 and 11: X step, low and high
  - 12 and 13: Y step, low and high
  - 14 and 15: source X, low and high
  - 16 and 17: source Y, low and high
- R3: Trigger condition and operation check:
  - A write to word 17 while idle launches a computation only if word 0 equals 0.
  - If word 0 holds any other value, `op_err` pulses for the cycle after the write, `busy` stays low, and the outputs keep their values.
- R4: The source start per axis is the upper 32 bits of the 64-bit source position. The source end per axis depends on control bit 0:
  - Bit 0 = 1: the upper 32 bits of (position + step × destination extent), taken modulo 2^64.
  - Bit 0 = 0: the integer start plus the destination extent, modulo 2^32.
- R5: The untrimmed destination end per axis is the destination start plus the destination extent, modulo 2^32.
- R6: First trim pass, per axis, with a = source span length, b = destination span length and t = a − source surface limit + source start (32-bit):
  - The excess e is t when t is non-negative as a signed 32-bit value, and 0 otherwise.
  - The destination end becomes destination start + b − ⌊e·b / a⌋, with the product taken over 64 bits and the result truncated to 32 bits.
  - The source end is reduced by e.
- R7: A second pass applies the same rule with the roles swapped. The destination span is the reference, checked against the destination surface limit, and the source span is the one shortened.
- R8: When a reference span length is zero, no division takes place. The excess is zero and the paired span is unchanged.
- R9: Timing of a launched computation:
  - `busy` is high from the cycle after the launching write until the results are presented.
  - Results, `filter` and a one-cycle `done` pulse appear 4·32+5 = 133 clock edges after the launching edge, at the same edge where `busy` falls.
- R10: The outputs hold their values between completions. Writes that arrive while busy, including writes to word 17, are stored but do not alter the computation in progress, and word 17 does not start a second computation.
- R11: The `filter` output presents control bits 2:1 as they stood when the computation was launched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register word index |
| wr_data | input | 32 | Register write data |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: rectangles valid |
| op_err | output | 1 | Pulse: trigger with a non-copy operation |
| idx_err | output | 1 | Pulse: write index out of range |
| filter | output | 2 | Filter mode captured at launch |
| src_x0 | output | 32 | Source rectangle left |
| src_y0 | output | 32 | Source rectangle top |
| src_x1 | output | 32 | Source rectangle right |
| src_y1 | output | 32 | Source rectangle bottom |
| dst_x0 | output | 32 | Destination rectangle left |
| dst_y0 | output | 32 | Destination rectangle top |
| dst_x1 | output | 32 | Destination rectangle right |
| dst_y1 | output | 32 | Destination rectangle bottom |

## Verification
The error pulses are due one clock after the offending write. `busy` is due one clock after a launching write, and the rectangles, `filter` and `done` are due exactly 133 edges after the launching edge. The bench's reference model advances on the same rising edges as the design. It latches the expected rectangles at the trigger and releases them when its own countdown of 133 edges expires. Every output is compared against that model on each falling edge, so an early, late or repeated result is reported on the cycle it happens.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int CW        = 32;
  localparam int NUM_WORDS = 18;

  typedef logic [CW-1:0]   word_t;
  typedef logic [2*CW-1:0] fix_t;

  // register word indices; the trigger word must be written last
  localparam int RI_OP      = 0;
  localparam int RI_CTRL    = 1;
  localparam int RI_SURF_SW = 2;
  localparam int RI_SURF_SH = 3;
  localparam int RI_SURF_DW = 4;
  localparam int RI_SURF_DH = 5;
  localparam int RI_DPOS_X  = 6;
  localparam int RI_DPOS_Y  = 7;
  localparam int RI_DEXT_X  = 8;
  localparam int RI_DEXT_Y  = 9;
  localparam int RI_STEPX_L = 10;
  localparam int RI_STEPX_H = 11;
  localparam int RI_STEPY_L = 12;
  localparam int RI_STEPY_H = 13;
  localparam int RI_SPOSX_L = 14;
  localparam int RI_SPOSX_H = 15;
  localparam int RI_SPOSY_L = 16;
  localparam int RI_SPOSY_H = 17;
  localparam int RI_TRIGGER = RI_SPOSY_H;

  localparam word_t OP_COPY = '0;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_CLIP1,
    PH_WAIT1,
    PH_CLIP2,
    PH_WAIT2
  } phase_e;

  // integer end of the source span for one axis
  function automatic word_t src_end(fix_t pos, fix_t step, word_t extent, logic stepped);
    fix_t prod;
    fix_t sum;
    prod = step * {{CW{1'b0}}, extent};
    sum  = pos + prod;
    if (stepped) return sum[2*CW-1:CW];
    return pos[2*CW-1:CW] + extent;
  endfunction

  // amount by which a span overruns its surface limit (zero-length span: none)
  function automatic word_t span_excess(word_t len, word_t origin, word_t limit);
    word_t t;
    if (len == '0) return '0;
    t = len - limit + origin;
    if (t[CW-1]) return '0;
    return t;
  endfunction

  // full-width product feeding the divider
  function automatic fix_t scaled(word_t ex, word_t paired);
    return {{CW{1'b0}}, ex} * {{CW{1'b0}}, paired};
  endfunction

  // divisor guard: a zero span divides by one (its dividend is zero anyway)
  function automatic word_t safe_divisor(word_t len);
    return (len == '0) ? word_t'(1) : len;
  endfunction

endpackage

// File: rtl/blit_regs.sv
module blit_regs
  import blit_pkg::*;
#(
  parameter int NREG = NUM_WORDS,
  parameter int IW   = 5,
  parameter int TRIG = RI_TRIGGER
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  word_t         wr_data,
  output word_t         regs_q [NREG],
  output logic          trig,
  output logic          idx_err
);

  localparam logic [IW:0] LIMIT = (IW+1)'(NREG);

  logic in_range;
  assign in_range = ({1'b0, wr_idx} < LIMIT);
  assign trig     = wr_en && in_range && (wr_idx == IW'(TRIG));

  for (genvar g = 0; g < NREG; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)                                  regs_q[g] <= '0;
      else if (wr_en && wr_idx == IW'(g))       regs_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_err <= 1'b0;
    else     idx_err <= wr_en && !in_range;
  end

  // R2: the reject flag only follows an out-of-range write
  a_r2_reject_follows_write: assert property (@(posedge clk) disable iff (rst)
    idx_err |-> $past(wr_en) && ({1'b0, $past(wr_idx)} >= LIMIT));

endmodule

// File: rtl/blit_div.sv
module blit_div #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  output logic [W-1:0]   quotient,
  output logic           done
);

  localparam int STEPS = 2 * W;
  localparam int CNTW  = $clog2(STEPS + 1);

  logic [W-1:0]    rem;
  logic [2*W-1:0]  quo;
  logic [W-1:0]    dvs;
  logic [CNTW-1:0] cnt;
  logic [W:0]      shifted;
  logic [W:0]      diff;
  logic            fits;

  assign shifted  = {rem, quo[2*W-1]};
  assign diff     = shifted - {1'b0, dvs};
  assign fits     = (shifted >= {1'b0, dvs});
  assign quotient = quo[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      quo  <= '0;
      dvs  <= '0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0;
        quo <= dividend;
        dvs <= divisor;
        cnt <= CNTW'(STEPS);
      end else if (cnt != '0) begin
        rem <= fits ? diff[W-1:0] : shifted[W-1:0];
        quo <= {quo[2*W-2:0], fits};
        cnt <= cnt - 1'b1;
        if (cnt == CNTW'(1)) done <= 1'b1;
      end
    end
  end

  // R8: a division is never launched on a zero divisor
  a_r8_divisor_nonzero: assert property (@(posedge clk) disable iff (rst)
    start |-> divisor != '0);

  // R9: completion is a single-cycle event
  a_r9_div_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/blit_clip_unit.sv
module blit_clip_unit
  import blit_pkg::*;
#(
  parameter  int NREG = NUM_WORDS,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [CW-1:0] wr_data,
  output logic          busy,
  output logic          done,
  output logic          op_err,
  output logic          idx_err,
  output logic [1:0]    filter,
  output logic [CW-1:0] src_x0,
  output logic [CW-1:0] src_y0,
  output logic [CW-1:0] src_x1,
  output logic [CW-1:0] src_y1,
  output logic [CW-1:0] dst_x0,
  output logic [CW-1:0] dst_y0,
  output logic [CW-1:0] dst_x1,
  output logic [CW-1:0] dst_y1
);

  localparam int AXES = 2;

  word_t  regs_q [NREG];
  logic   trig;
  phase_e ph;
  logic   op_ok;
  logic   launch;
  logic   reject;
  logic   pass1;
  logic   div_go;
  logic   div_done [AXES];
  logic   both_done;
  logic   finish;
  logic   stepped;
  logic [1:0] filt_q;

  word_t o_s1 [AXES];
  word_t o_s2 [AXES];
  word_t o_d1 [AXES];
  word_t o_d2 [AXES];

  blit_regs #(.NREG(NREG), .IW(IW), .TRIG(RI_TRIGGER)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs_q  (regs_q),
    .trig    (trig),
    .idx_err (idx_err)
  );

  assign op_ok     = (regs_q[RI_OP] == OP_COPY);
  assign launch    = trig && (ph == PH_IDLE) && op_ok;
  assign reject    = trig && (ph == PH_IDLE) && !op_ok;
  assign pass1     = (ph == PH_CLIP1);
  assign div_go    = (ph == PH_CLIP1) || (ph == PH_CLIP2);
  assign both_done = div_done[0] && div_done[1];
  assign finish    = (ph == PH_WAIT2) && both_done;
  assign stepped   = regs_q[RI_CTRL][0];
  assign busy      = (ph != PH_IDLE);

  // phase sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_IDLE;
    end else begin
      unique case (ph)
        PH_IDLE:  if (launch) ph <= PH_SETUP;
        PH_SETUP: ph <= PH_CLIP1;
        PH_CLIP1: ph <= PH_WAIT1;
        PH_WAIT1: if (both_done) ph <= PH_CLIP2;
        PH_CLIP2: ph <= PH_WAIT2;
        PH_WAIT2: if (both_done) ph <= PH_IDLE;
        default:  ph <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      op_err <= 1'b0;
      filt_q <= '0;
      filter <= '0;
    end else begin
      done   <= finish;
      op_err <= reject;
      if (ph == PH_SETUP) filt_q <= regs_q[RI_CTRL][2:1];
      if (finish)         filter <= filt_q;
    end
  end

  for (genvar ax = 0; ax < AXES; ax++) begin : g_axis
    localparam int I_SPL = (ax == 0) ? RI_SPOSX_L : RI_SPOSY_L;
    localparam int I_SPH = (ax == 0) ? RI_SPOSX_H : RI_SPOSY_H;
    localparam int I_STL = (ax == 0) ? RI_STEPX_L : RI_STEPY_L;
    localparam int I_STH = (ax == 0) ? RI_STEPX_H : RI_STEPY_H;
    localparam int I_DP  = (ax == 0) ? RI_DPOS_X  : RI_DPOS_Y;
    localparam int I_DE  = (ax == 0) ? RI_DEXT_X  : RI_DEXT_Y;
    localparam int I_SL  = (ax == 0) ? RI_SURF_SW : RI_SURF_SH;
    localparam int I_DL  = (ax == 0) ? RI_SURF_DW : RI_SURF_DH;

    fix_t  pos_fix;
    fix_t  step_fix;
    word_t s1, s2, d1, d2, lsrc, ldst, ex_q, bb_q;
    word_t span_a, span_b, origin, limit, ex_c, dvr;
    fix_t  dvd;
    word_t q_lo, paired, fin_s2, fin_d2;

    assign pos_fix  = {regs_q[I_SPH], regs_q[I_SPL]};
    assign step_fix = {regs_q[I_STH], regs_q[I_STL]};

    // pass 1 references the source span; pass 2 the destination span
    assign span_a = pass1 ? (s2 - s1) : (d2 - d1);
    assign span_b = pass1 ? (d2 - d1) : (s2 - s1);
    assign origin = pass1 ? s1 : d1;
    assign limit  = pass1 ? lsrc : ldst;
    assign ex_c   = span_excess(span_a, origin, limit);
    assign dvr    = safe_divisor(span_a);
    assign dvd    = scaled(ex_c, span_b);

    blit_div #(.W(CW)) u_div (
      .clk      (clk),
      .rst      (rst),
      .start    (div_go),
      .dividend (dvd),
      .divisor  (dvr),
      .quotient (q_lo),
      .done     (div_done[ax])
    );

    assign paired = bb_q - q_lo;
    assign fin_s2 = paired + s1;
    assign fin_d2 = d2 - ex_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= '0; s2 <= '0; d1 <= '0; d2 <= '0;
        lsrc <= '0; ldst <= '0; ex_q <= '0; bb_q <= '0;
      end else begin
        unique case (ph)
          PH_SETUP: begin
            s1   <= pos_fix[2*CW-1:CW];
            s2   <= src_end(pos_fix, step_fix, regs_q[I_DE], stepped);
            d1   <= regs_q[I_DP];
            d2   <= regs_q[I_DP] + regs_q[I_DE];
            lsrc <= regs_q[I_SL];
            ldst <= regs_q[I_DL];
          end
          PH_CLIP1, PH_CLIP2: begin
            ex_q <= ex_c;
            bb_q <= span_b;
          end
          PH_WAIT1: if (both_done) begin
            d2 <= paired + d1;
            s2 <= s2 - ex_q;
          end
          PH_WAIT2: if (both_done) begin
            s2 <= fin_s2;
            d2 <= fin_d2;
          end
          default: ;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        o_s1[ax] <= '0; o_s2[ax] <= '0; o_d1[ax] <= '0; o_d2[ax] <= '0;
      end else if (finish) begin
        o_s1[ax] <= s1;
        o_s2[ax] <= fin_s2;
        o_d1[ax] <= d1;
        o_d2[ax] <= fin_d2;
      end
    end
  end

  assign src_x0 = o_s1[0];
  assign src_y0 = o_s1[1];
  assign src_x1 = o_s2[0];
  assign src_y1 = o_s2[1];
  assign dst_x0 = o_d1[0];
  assign dst_y0 = o_d1[1];
  assign dst_x1 = o_d2[0];
  assign dst_y1 = o_d2[1];

  // R9: done is a single pulse, and busy only ends on that pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_busy_ends_on_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R9: the two axis dividers run in lockstep
  a_r9_axes_lockstep: assert property (@(posedge clk) disable iff (rst)
    div_done[0] == div_done[1]);

  // R3: a rejected trigger never starts work
  a_r3_reject_stays_idle: assert property (@(posedge clk) disable iff (rst)
    op_err |-> !busy);

  // R10: results move only together with the done pulse
  a_r10_hold_between: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(src_x0) && $stable(src_y0) && $stable(src_x1) && $stable(src_y1)
           && $stable(dst_x0) && $stable(dst_y0) && $stable(dst_x1) && $stable(dst_y1)
           && $stable(filter));

endmodule

// File: tb/blit_clip_unit_test.sv
`timescale 1ns/1ps
module blit_clip_unit_test;

  localparam int LAT = 4 * 32 + 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        busy, done, op_err, idx_err;
  logic [1:0]  filter;
  logic [31:0] src_x0, src_y0, src_x1, src_y1, dst_x0, dst_y0, dst_x1, dst_y1;

  blit_clip_unit uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .busy(busy), .done(done), .op_err(op_err), .idx_err(idx_err), .filter(filter),
    .src_x0(src_x0), .src_y0(src_y0), .src_x1(src_x1), .src_y1(src_y1),
    .dst_x0(dst_x0), .dst_y0(dst_y0), .dst_x1(dst_x1), .dst_y1(dst_y1)
  );

  always #2 clk = ~clk;

  int    vectors = 0;
  int    fails = 0;
  bit    started = 0;
  bit    reported = 0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] mreg [18];
  int          countdown = 0;
  logic        e_busy = 0, e_done = 0, e_operr = 0, e_idxerr = 0;
  logic [1:0]  e_filter = 0, p_filter = 0;
  logic [31:0] e_rect [8];
  logic [31:0] p_rect [8];

  function automatic logic [31:0] end_of(input logic [63:0] st, input logic [63:0] stp,
                                         input logic [31:0] ext, input bit corner);
    logic [63:0] acc;
    if (!corner) return st[63:32] + ext;
    acc = st + stp * {32'd0, ext};
    return acc[63:32];
  endfunction

  // returns {new end of paired span, new end of reference span}
  function automatic logic [63:0] trim(input logic [31:0] rlo, input logic [31:0] rhi,
                                       input logic [31:0] olo, input logic [31:0] ohi,
                                       input logic [31:0] lim);
    logic [31:0] len, pl, t, ex;
    logic [63:0] q;
    len = rhi - rlo;
    pl  = ohi - olo;
    t   = len - lim + rlo;
    ex  = (len == 0 || $signed(t) < 0) ? 32'd0 : t;
    q   = (len == 0) ? 64'd0 : ({32'd0, ex} * {32'd0, pl}) / {32'd0, len};
    return {olo + pl - q[31:0], rhi - ex};
  endfunction

  task automatic predict();
    logic [31:0] sx, sxe, sy, sye, dx, dxe, dy, dye;
    logic [63:0] r;
    bit corner;
    corner = mreg[1][0];
    sx  = mreg[15];
    sy  = mreg[17];
    sxe = end_of({mreg[15], mreg[14]}, {mreg[11], mreg[10]}, mreg[8], corner);
    sye = end_of({mreg[17], mreg[16]}, {mreg[13], mreg[12]}, mreg[9], corner);
    dx  = mreg[6];
    dy  = mreg[7];
    dxe = dx + mreg[8];
    dye = dy + mreg[9];
    r = trim(sx, sxe, dx, dxe, mreg[2]); dxe = r[63:32]; sxe = r[31:0];
    r = trim(sy, sye, dy, dye, mreg[3]); dye = r[63:32]; sye = r[31:0];
    r = trim(dx, dxe, sx, sxe, mreg[4]); sxe = r[63:32]; dxe = r[31:0];
    r = trim(dy, dye, sy, sye, mreg[5]); sye = r[63:32]; dye = r[31:0];
    p_rect[0] = sx;  p_rect[1] = sy;  p_rect[2] = sxe; p_rect[3] = sye;
    p_rect[4] = dx;  p_rect[5] = dy;  p_rect[6] = dxe; p_rect[7] = dye;
    p_filter  = mreg[1][2:1];
  endtask

  always @(posedge clk) begin
    bit was_busy;
    started = 1;
    if (rst) begin
      for (int i = 0; i < 18; i++) mreg[i] = '0;
      for (int i = 0; i < 8; i++) e_rect[i] = '0;
      e_busy = 0; e_done = 0; e_operr = 0; e_idxerr = 0; e_filter = 0; countdown = 0;
    end else begin
      was_busy = e_busy;
      e_done = 0; e_operr = 0; e_idxerr = 0;
      if (countdown > 0) begin
        countdown--;
        if (countdown == 0) begin
          e_busy = 0; e_done = 1; e_filter = p_filter;
          for (int i = 0; i < 8; i++) e_rect[i] = p_rect[i];
        end
      end
      if (wr_en) begin
        if (wr_idx >= 5'd18) e_idxerr = 1;
        else begin
          mreg[wr_idx] = wr_data;
          if (wr_idx == 5'd17 && !was_busy) begin
            if (mreg[0] != 0) e_operr = 1;
            else begin
              predict();
              e_busy = 1;
              countdown = LAT;
            end
          end
        end
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", cur_req, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      chk("busy (R9)", 32'(busy), 32'(e_busy));
      chk("done (R9)", 32'(done), 32'(e_done));
      chk("op_err (R3)", 32'(op_err), 32'(e_operr));
      chk("idx_err (R2)", 32'(idx_err), 32'(e_idxerr));
      chk("filter (R11)", 32'(filter), 32'(e_filter));
      chk("src_x0", src_x0, e_rect[0]);
      chk("src_y0", src_y0, e_rect[1]);
      chk("src_x1", src_x1, e_rect[2]);
      chk("src_y1", src_y1, e_rect[3]);
      chk("dst_x0", dst_x0, e_rect[4]);
      chk("dst_y0", dst_y0, e_rect[5]);
      chk("dst_x1", dst_x1, e_rect[6]);
      chk("dst_y1", dst_y1, e_rect[7]);
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic wr(input int idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = data;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic load(input logic [31:0] op, input logic [31:0] ctrl,
                      input logic [31:0] sw, input logic [31:0] sh,
                      input logic [31:0] tw, input logic [31:0] th,
                      input logic [31:0] dx, input logic [31:0] dy,
                      input logic [31:0] dw, input logic [31:0] dh,
                      input logic [63:0] stx, input logic [63:0] sty,
                      input logic [63:0] sx, input logic [63:0] sy);
    wr(0, op);  wr(1, ctrl);
    wr(2, sw);  wr(3, sh);  wr(4, tw);  wr(5, th);
    wr(6, dx);  wr(7, dy);  wr(8, dw);  wr(9, dh);
    wr(10, stx[31:0]); wr(11, stx[63:32]);
    wr(12, sty[31:0]); wr(13, sty[63:32]);
    wr(14, sx[31:0]);  wr(15, sx[63:32]);
    wr(16, sy[31:0]);  wr(17, sy[63:32]);
  endtask

  task automatic settle();
    repeat (LAT + 4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    cur_req = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    cur_req = "R5";   // direct origin, nothing clipped
    load(0, 0, 100, 100, 100, 100, 10, 20, 30, 40, 0, 0, {32'd5, 32'd0}, {32'd7, 32'd0});
    settle();

    cur_req = "R6";   // source overruns its surface in X
    load(0, 32'h2, 20, 100, 100, 100, 10, 20, 30, 40, 0, 0, {32'd5, 32'd0}, {32'd7, 32'd0});
    settle();

    cur_req = "R4";   // stepped origin with fractional positions, filter 3
    load(0, 32'h7, 15, 100, 100, 100, 0, 0, 10, 9,
         {32'd2, 32'd0}, {32'd0, 32'h8000_0000},
         {32'd3, 32'h4000_0000}, {32'd1, 32'h8000_0000});
    settle();

    cur_req = "R7";   // destination surface trims in both axes
    load(0, 32'h0, 1000, 1000, 30, 25, 20, 10, 25, 25, 0, 0, {32'd40, 32'd0}, {32'd0, 32'd0});
    settle();

    cur_req = "R7";   // both passes active, stepped 1.5
    load(0, 32'h1, 40, 40, 25, 25, 12, 12, 30, 30,
         {32'd1, 32'h8000_0000}, {32'd1, 32'h8000_0000},
         {32'd10, 32'd0}, {32'd10, 32'd0});
    settle();

    cur_req = "R8";   // zero step: zero-length source spans
    load(0, 32'h1, 50, 50, 50, 50, 5, 6, 8, 8, 0, 0, {32'd60, 32'd0}, {32'd70, 32'd0});
    settle();

    cur_req = "R3";   // non-copy operation is refused
    wr(0, 32'd9);
    wr(17, 32'd3);
    repeat (6) @(negedge clk);
    wr(0, 32'd0);

    cur_req = "R2";   // out-of-range index has no effect
    wr(20, 32'hDEAD_BEEF);
    wr(31, 32'h0000_0001);
    wr(17, 32'd70);
    settle();

    cur_req = "R10";  // writes and a retrigger while busy
    wr(6, 32'd3);
    wr(17, 32'd7);
    repeat (10) @(negedge clk);
    wr(6, 32'd500);
    wr(17, 32'd8);
    settle();
    wr(17, 32'd8);
    settle();

    cur_req = "R11";  // filter captured at launch, changed while busy
    wr(1, 32'h4);
    wr(17, 32'd2);
    repeat (5) @(negedge clk);
    wr(1, 32'h2);
    settle();

    cur_req = "R9";   // plain run watched for timing
    load(0, 32'h0, 64, 64, 64, 64, 1, 2, 3, 4, 0, 0, {32'd9, 32'd0}, {32'd8, 32'd0});
    settle();

    report();
  end

endmodule